// File: doc/BRIEF.md
# UART DMA Flow-Control Handshake Unit

This unit sits on the UART side of a DMA path. It makes the peripheral, and not the DMA engine, the flow controller for both directions. Software programs one control word per direction. The word holds an enable, a burst length code and a block length in words. The unit then compares the transmit FIFO free space, or the receive FIFO fill level, with the programmed burst. It raises either a burst request or a single-word request to the external DMA engine. It counts the words that each acknowledged request moves, and it marks the request that completes the block with a last-transfer flag.

A receive block can be cut short by software. When a receive timeout occurs while data is still pending, the driver writes zero to the receive control word and then writes 1 to the acknowledge register. The unit then emits a last-transfer pulse on the receive side at once and drops any remaining count. To reprogram a direction, software writes zero to its control word and then writes the new value.

Top module: `uart_dma_fc`

## Requirements
- R1: After reset, all six request and last-transfer outputs are low.
- R2: The transmit control word is written at address 0x10C, the receive control word at 0x110 and the software acknowledge at 0xA8. A write to any other address has no effect on the outputs.
- R3: Control word fields are as follows. Bit 0 enables the direction. Bits [2:1] select the burst: 00 is 1 word, 01 is 4 words, 11 is 8 words, and the unused code 10 is 1 word. Bits [BLK_W+2:3] hold the block length in words. A write with the enable clear, or with a block length of zero, produces no request.
- R4: A transmit burst request rises when the direction is enabled, at least one burst of words remains, and the transmit FIFO free count is at least the burst length.
- R5: A receive burst request rises when the direction is enabled, at least one burst of words remains, and the receive FIFO fill count is at least the burst length. With fewer words in the FIFO, no request is raised.
- R6: When fewer words than one burst remain, single-word requests are raised, one at a time, as long as the FIFO level is at least 1.
- R7: A request stays asserted until its acknowledge is seen. An acknowledge removes the burst length (burst request) or one word (single request) from the remaining count. The next request appears no earlier than the cycle after the acknowledge.
- R8: The last-transfer output is high together with the request whose acknowledge completes the block. After that acknowledge, no further request is raised until the control word is written again.
- R9: Writing zero to a control word clears that direction's pending request and remaining count from the next cycle. No request follows, whatever the FIFO level.
- R10: Writing a value with bit 0 set to the acknowledge address ends the receive block. On the next cycle the receive last-transfer output is high for exactly one cycle, the receive request is low and the remaining count is cleared. The transmit side is not affected, and a write with bit 0 clear has no effect.
- R11: A direction never asserts its burst request and its single request at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| tx_fifo_free | input | LVL_W | Free entries in the transmit FIFO |
| rx_fifo_fill | input | LVL_W | Occupied entries in the receive FIFO |
| tx_dma_ack | input | 1 | DMA engine finished the pending transmit request |
| rx_dma_ack | input | 1 | DMA engine finished the pending receive request |
| tx_burst_req | output | 1 | Transmit burst request |
| tx_single_req | output | 1 | Transmit single-word request |
| tx_last | output | 1 | Transmit request completes the block |
| rx_burst_req | output | 1 | Receive burst request |
| rx_single_req | output | 1 | Receive single-word request |
| rx_last | output | 1 | Receive request completes the block, or forced end |

## Verification
The request sequence is exercised with several block and burst combinations.

- A transmit block of 10 with burst 4 shows the switch from burst to single requests and where the last flag lands.
- A receive block of 16 with burst 8 ends exactly on a burst boundary.
- A receive block of 3 under the unused burst code shows that the code falls back to one word.
- A one-word transmit block has its first request flagged as last.

Held-back FIFO levels separate level gating from count gating. Unacknowledged requests separate the hold behaviour from the zero-write clear and the software-forced end. Writes to a wrong address, with enable clear, or with zero length show that nothing starts.

// File: rtl/uart_dma_fc_pkg.sv
package uart_dma_fc_pkg;

  localparam logic [11:0] TX_CTRL_ADDR = 12'h10C;
  localparam logic [11:0] RX_CTRL_ADDR = 12'h110;
  localparam logic [11:0] SWACK_ADDR   = 12'h0A8;

  typedef enum logic [1:0] {
    BURST_ONE   = 2'b00,
    BURST_FOUR  = 2'b01,
    BURST_SPARE = 2'b10,
    BURST_EIGHT = 2'b11
  } burst_code_e;

  function automatic logic [3:0] burst_words(input logic [1:0] code);
    case (burst_code_e'(code))
      BURST_FOUR:  burst_words = 4'd4;
      BURST_EIGHT: burst_words = 4'd8;
      default:     burst_words = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/uart_dma_fc_regs.sv
module uart_dma_fc_regs
  import uart_dma_fc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        cfg_we,
  output logic              cfg_en,
  output logic [1:0]        cfg_burst,
  output logic [BLK_W-1:0]  cfg_size,
  output logic              swack
);

  localparam int SIZE_LSB = 3;
  localparam int SIZE_MSB = SIZE_LSB + BLK_W - 1;

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:SIZE_MSB+1];

  assign cfg_we[0] = wr_en && (wr_addr == ADDR_W'(TX_CTRL_ADDR));
  assign cfg_we[1] = wr_en && (wr_addr == ADDR_W'(RX_CTRL_ADDR));
  assign swack     = wr_en && (wr_addr == ADDR_W'(SWACK_ADDR)) && wr_data[0];

  assign cfg_en    = wr_data[0];
  assign cfg_burst = wr_data[2:1];
  assign cfg_size  = wr_data[SIZE_MSB:SIZE_LSB];

  // R2: a single write reaches at most one register
  a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_we, swack}));

endmodule

// File: rtl/uart_dma_fc_chan.sv
module uart_dma_fc_chan
  import uart_dma_fc_pkg::*;
#(
  parameter int BLK_W     = 12,
  parameter int LVL_W     = 5,
  parameter bit HAS_FORCE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_burst,
  input  logic [BLK_W-1:0] cfg_size,
  input  logic             force_end,
  input  logic [LVL_W-1:0] level,
  input  logic             ack,
  output logic             burst_req,
  output logic             single_req,
  output logic             last
);

  logic             active;
  logic [BLK_W-1:0] remaining;
  logic [3:0]       blen;
  logic             burst_q, single_q, last_q;

  logic             pend, take, force_eff;
  logic             want_burst, want_single;
  logic [BLK_W-1:0] blen_blk, grant_len, rem_next;
  logic [LVL_W-1:0] blen_lvl;

  generate
    if (HAS_FORCE) begin : g_force
      assign force_eff = force_end;
    end else begin : g_noforce
      logic unused_force;
      assign unused_force = force_end;
      assign force_eff    = 1'b0;
    end
  endgenerate

  assign blen_blk  = BLK_W'(blen);
  assign blen_lvl  = LVL_W'(blen);
  assign pend      = burst_q | single_q;
  assign take      = ack & pend;
  assign grant_len = burst_q ? blen_blk : BLK_W'(1);
  assign rem_next  = remaining - grant_len;

  assign want_burst  = active && !pend && (remaining >= blen_blk) && (level >= blen_lvl);
  assign want_single = active && !pend && (remaining < blen_blk) && (remaining != '0)
                       && (level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      remaining <= '0;
      blen      <= 4'd1;
      burst_q   <= 1'b0;
      single_q  <= 1'b0;
      last_q    <= 1'b0;
    end else if (cfg_we) begin
      active    <= cfg_en && (cfg_size != '0);
      remaining <= cfg_en ? cfg_size : '0;
      blen      <= burst_words(cfg_burst);
      burst_q   <= 1'b0;
      single_q  <= 1'b0;
      last_q    <= 1'b0;
    end else if (force_eff) begin
      active    <= 1'b0;
      remaining <= '0;
      burst_q   <= 1'b0;
      single_q  <= 1'b0;
      last_q    <= 1'b1;
    end else if (take) begin
      remaining <= rem_next;
      if (rem_next == '0) active <= 1'b0;
      burst_q   <= 1'b0;
      single_q  <= 1'b0;
      last_q    <= 1'b0;
    end else if (want_burst) begin
      burst_q <= 1'b1;
      last_q  <= (remaining == blen_blk);
    end else if (want_single) begin
      single_q <= 1'b1;
      last_q   <= (remaining == BLK_W'(1));
    end else if (!pend) begin
      last_q <= 1'b0;
    end
  end

  assign burst_req  = burst_q;
  assign single_req = single_q;
  assign last       = last_q;

  // R11: burst and single request are mutually exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(burst_q && single_q));

  // R7: a request holds steady until acknowledged
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack && !cfg_we && !force_eff) |=> $stable({burst_q, single_q, last_q}));

  // R7: no request in the cycle after an acknowledge
  a_r7_gap: assert property (@(posedge clk) disable iff (rst)
    take |=> !(burst_q || single_q));

  // R9: a zero write drops any request
  a_r9_zero_clear: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_en) |=> !(burst_q || single_q));

  // R10: forced end gives last with no request
  a_r10_force: assert property (@(posedge clk) disable iff (rst)
    (force_eff && !cfg_we) |=> (last_q && !burst_q && !single_q));

  // R4 / R5: a burst request only rises with enough FIFO level
  a_r4_level: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_q) |-> ($past(level) >= blen_lvl));

endmodule

// File: rtl/uart_dma_fc.sv
module uart_dma_fc #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int BLK_W      = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  tx_fifo_free,
  input  logic [LVL_W-1:0]  rx_fifo_fill,
  input  logic              tx_dma_ack,
  input  logic              rx_dma_ack,
  output logic              tx_burst_req,
  output logic              tx_single_req,
  output logic              tx_last,
  output logic              rx_burst_req,
  output logic              rx_single_req,
  output logic              rx_last
);

  localparam int NCH = 2;

  logic [1:0]       cfg_we;
  logic             cfg_en;
  logic [1:0]       cfg_burst;
  logic [BLK_W-1:0] cfg_size;
  logic             swack;

  logic [LVL_W-1:0] lvl [NCH];
  logic [NCH-1:0]   ack_v, breq, sreq, lst;

  assign lvl[0] = tx_fifo_free;
  assign lvl[1] = rx_fifo_fill;
  assign ack_v  = {rx_dma_ack, tx_dma_ack};

  uart_dma_fc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_burst(cfg_burst), .cfg_size(cfg_size),
    .swack(swack)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      uart_dma_fc_chan #(
        .BLK_W(BLK_W), .LVL_W(LVL_W), .HAS_FORCE(i == 1)
      ) u_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we[i]), .cfg_en(cfg_en),
        .cfg_burst(cfg_burst), .cfg_size(cfg_size), .force_end(swack),
        .level(lvl[i]), .ack(ack_v[i]),
        .burst_req(breq[i]), .single_req(sreq[i]), .last(lst[i])
      );
    end
  endgenerate

  assign tx_burst_req  = breq[0];
  assign tx_single_req = sreq[0];
  assign tx_last       = lst[0];
  assign rx_burst_req  = breq[1];
  assign rx_single_req = sreq[1];
  assign rx_last       = lst[1];

endmodule

// File: tb/uart_dma_fc_bench.sv
module uart_dma_fc_bench;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 5;
  localparam logic [11:0] A_TX = 12'h10C, A_RX = 12'h110, A_ACK = 12'h0A8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [LVL_W-1:0] tx_free = '0, rx_fill = '0;
  logic tx_ack = 1'b0, rx_ack = 1'b0;
  logic tx_b, tx_s, tx_l, rx_b, rx_s, rx_l;

  int errors = 0, checks = 0;
  logic [1:0] tx_q[$];
  logic [1:0] rx_q[$];
  bit tx_auto = 1'b0, rx_auto = 1'b0;

  uart_dma_fc u_uart_dma_fc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_fifo_free(tx_free), .rx_fifo_fill(rx_fill),
    .tx_dma_ack(tx_ack), .rx_dma_ack(rx_ack),
    .tx_burst_req(tx_b), .tx_single_req(tx_s), .tx_last(tx_l),
    .rx_burst_req(rx_b), .rx_single_req(rx_s), .rx_last(rx_l)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(int en, int code, int size);
    return 32'((size << 3) | (code << 1) | en);
  endfunction

  // driver side of the scoreboard: expected {is_burst, last} per request
  task automatic plan(bit rx, int size, int b);
    int rem = size;
    while (rem > 0) begin
      logic [1:0] item;
      if (rem >= b) begin item = {1'b1, rem == b}; rem -= b; end
      else begin item = {1'b0, rem == 1}; rem -= 1; end
      if (rx) rx_q.push_back(item); else tx_q.push_back(item);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic drain(bit rx);
    while ((rx ? rx_q.size() : tx_q.size()) != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // monitor side: act as the DMA engine and compare each request
  always @(negedge clk) begin
    if (tx_ack) tx_ack = 1'b0;
    else if (tx_auto && !rst && (tx_b || tx_s)) begin
      if (tx_q.size() == 0) check_eq("R8", "tx request after block end", 1, 0);
      else check_eq("R4/R6/R8", "tx {burst,last}", int'({tx_b, tx_l}), int'(tx_q.pop_front()));
      tx_ack = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rx_ack) rx_ack = 1'b0;
    else if (rx_auto && !rst && (rx_b || rx_s)) begin
      if (rx_q.size() == 0) check_eq("R8", "rx request after block end", 1, 0);
      else check_eq("R5/R6/R8", "rx {burst,last}", int'({rx_b, rx_l}), int'(rx_q.pop_front()));
      rx_ack = 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check_eq("R1", "outputs after reset", int'({tx_b, tx_s, tx_l, rx_b, rx_s, rx_l}), 0);
    rst = 1'b0;
    tx_free = 5'd16; rx_fill = 5'd16;
    tx_auto = 1'b1; rx_auto = 1'b1;

    // R4 R6 R8: tx block 10, burst 4 -> B B S S(last)
    plan(1'b0, 10, 4);
    wr(A_TX, cfg(1, 1, 10));
    drain(1'b0);
    check_eq("R8", "tx idle after block", int'({tx_b, tx_s}), 0);

    // R5: rx block 16, burst 8 -> B B(last)
    plan(1'b1, 16, 8);
    wr(A_RX, cfg(1, 3, 16));
    drain(1'b1);

    // R3: spare code 10 means one word
    plan(1'b1, 3, 1);
    wr(A_RX, cfg(1, 2, 3));
    drain(1'b1);
    check_eq("R8", "rx idle after block", int'({rx_b, rx_s}), 0);

    // R8: one-word tx block is last at once
    plan(1'b0, 1, 1);
    wr(A_TX, cfg(1, 0, 1));
    drain(1'b0);

    // R3: zero length and enable clear start nothing
    wr(A_TX, cfg(1, 1, 0));
    repeat (8) @(negedge clk);
    check_eq("R3", "tx request with zero length", int'({tx_b, tx_s}), 0);
    wr(A_TX, cfg(0, 1, 8));
    repeat (8) @(negedge clk);
    check_eq("R3", "tx request with enable clear", int'({tx_b, tx_s}), 0);

    // R2: a write to a wrong address is ignored
    wr(12'h108, cfg(1, 0, 5));
    repeat (8) @(negedge clk);
    check_eq("R2", "requests after stray write", int'({tx_b, tx_s, rx_b, rx_s}), 0);

    // R5 R7 R9: level gating, hold, zero-write clear
    rx_auto = 1'b0; rx_fill = 5'd3;
    wr(A_RX, cfg(1, 1, 8));
    repeat (6) @(negedge clk);
    check_eq("R5", "rx request with fill below burst", int'({rx_b, rx_s}), 0);
    rx_fill = 5'd4;
    repeat (3) @(negedge clk);
    check_eq("R5", "rx burst request at fill 4", int'(rx_b), 1);
    check_eq("R11", "rx single with burst", int'(rx_s), 0);
    check_eq("R8", "rx last on first of two bursts", int'(rx_l), 0);
    repeat (5) @(negedge clk);
    check_eq("R7", "rx burst held without ack", int'(rx_b), 1);
    wr(A_RX, 32'd0);
    check_eq("R9", "rx request after zero write", int'({rx_b, rx_s}), 0);
    rx_fill = 5'd16;
    repeat (6) @(negedge clk);
    check_eq("R9", "rx request after clear, full FIFO", int'({rx_b, rx_s, rx_l}), 0);

    // R10: software-forced end
    tx_auto = 1'b0;
    wr(A_TX, cfg(1, 3, 16));
    wr(A_RX, cfg(1, 3, 20));
    repeat (3) @(negedge clk);
    check_eq("R4", "tx burst pending", int'(tx_b), 1);
    check_eq("R5", "rx burst pending", int'(rx_b), 1);
    wr(A_ACK, 32'd0);
    check_eq("R10", "ack bit clear gives no last", int'({rx_b, rx_l}), 2);
    wr(A_RX, 32'd0);
    wr(A_ACK, 32'd1);
    check_eq("R10", "rx last after zero+ack", int'(rx_l), 1);
    @(negedge clk);
    check_eq("R10", "rx last one cycle only", int'(rx_l), 0);
    wr(A_RX, cfg(1, 3, 20));
    repeat (3) @(negedge clk);
    wr(A_ACK, 32'd1);
    check_eq("R10", "rx {burst,single,last} after forced end", int'({rx_b, rx_s, rx_l}), 1);
    @(negedge clk);
    check_eq("R10", "rx last drops", int'(rx_l), 0);
    repeat (6) @(negedge clk);
    check_eq("R10", "rx count cleared", int'({rx_b, rx_s}), 0);
    check_eq("R10", "tx burst untouched", int'(tx_b), 1);
    wr(A_TX, 32'd0);
    check_eq("R9", "tx request after zero write", int'({tx_b, tx_s}), 0);

    check_eq("R8", "scoreboard drained", tx_q.size() + rx_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule